// File: doc/BRIEF.md
# Biphase Line Bit Recovery

This block recovers the data bits and a bit-timing strobe from a two-level biphase line. The line changes level at the start of every bit cell. A cell that holds a 1 has no change of level in its middle. A cell that holds a 0 has one extra change in the middle. The block runs from a sampling clock at twelve ticks per bit cell. The line input passes through a two-flop synchroniser. The block then waits for a cell-boundary transition in the polarity it expects.

Once a boundary is found, the block does not look for edges until a fixed sample tick inside the cell. At that tick it reads the line and decodes the bit. It then works out the polarity of the next boundary from the level it read. A one-clock ready pulse is raised at each boundary. This pulse announces the bit of the cell that has just ended, which is still present on the data output. A test strobe falls shortly after each boundary and rises at the sample tick, so the sample point can be observed.

The block is intended to sit in front of a byte or frame aligner. That aligner shifts in `data_o` on each `bit_rdy_o` pulse.

Top module: `bpr_bit_recovery`

## Requirements
- R1: After reset the block waits for a low-to-high transition on `line_i`. The first boundary only opens the first cell and gives no `bit_rdy_o` pulse. No pulse appears before a bit has been decoded.
- R2: At the sample tick the bit decodes as 1 when the line level equals the level just after the boundary, and as 0 when it differs (a mid-cell change means 0).
- R3: Every boundary after the first raises `bit_rdy_o` for exactly one clock. The pulse is visible in the third clock after the first rising clock edge that captures the new line level, and `data_o` then holds the bit of the cell that just ended.
- R4: The next boundary is expected to drive the line to the inverse of the level read at the sample tick. Boundaries of both polarities are therefore followed across a stream.
- R5: `strobe_o` is low from 3 clocks after the `bit_rdy_o` pulse and rises 7 clocks after the pulse, at the sample tick. It stays high until the next cell's low point.
- R6: A line change between a boundary and the sample tick is never taken as a boundary.
- R7: `data_o` changes only in the clock in which `strobe_o` rises, and holds its value until the next sample tick.
- R8: While `rst_n` is low, `data_o`, `bit_rdy_o` and `strobe_o` are 0. A reset in the middle of a stream restarts the hunt for a rising boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, twelve ticks per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Biphase line, asynchronous to clk |
| data_o | output | 1 | Recovered bit, updated at each sample tick |
| bit_rdy_o | output | 1 | One-clock pulse at each boundary after the first |
| strobe_o | output | 1 | Test strobe; its rising edge marks the sample tick |

## Verification
The hardest case to reach from the ports is a mid-cell line change that arrives while the block is blind to edges. That change must be shown to produce neither a pulse nor a polarity slip. The stimulus table therefore includes all-zero and alternating bytes, which put a mid-cell change in many cells in a row, next to all-one bytes that have none. Every pulse is checked for its latency from the driven boundary and for the bit it announces. A reset in the middle of a stream, followed by a fresh start, shows that the first boundary after the restart stays silent.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  // Decoded value: a level that survives to the sample tick is a 1.
  function automatic logic bpr_decode(input logic lvl_at_edge, input logic lvl_at_smp);
    return (lvl_at_edge == lvl_at_smp);
  endfunction

  // The next boundary always drives the line away from the level that was sampled.
  function automatic logic bpr_next_level(input logic lvl_at_smp);
    return ~lvl_at_smp;
  endfunction

endpackage

// File: rtl/bpr_sync.sv
module bpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bpr_edge_det.sv
module bpr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic armed_i,
  input  logic load_i,
  input  logic want_lvl_i,
  output logic edge_hit_o
);
  logic line_q;
  logic want_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      want_q <= 1'b1;   // hunt starts with a rising boundary
    end else begin
      line_q <= line_s;
      if (load_i) want_q <= want_lvl_i;
    end
  end

  assign edge_hit_o = armed_i && (line_s != line_q) && (line_s == want_q);
endmodule

// File: rtl/bpr_cell_timer.sv
module bpr_cell_timer #(
  parameter int TICKS_PER_BIT = 12,
  parameter int DROP_TICK     = 3,
  parameter int SAMPLE_TICK   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic in_cell_o,
  output logic drop_o,
  output logic sample_o
);
  localparam int CW = $clog2(TICKS_PER_BIT + 1);
  localparam logic [CW-1:0] DROP_C   = CW'(DROP_TICK);
  localparam logic [CW-1:0] SAMPLE_C = CW'(SAMPLE_TICK);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == SAMPLE_C) busy_q <= 1'b0;
    end
  end

  assign in_cell_o = busy_q;
  assign drop_o    = busy_q && (cnt_q == DROP_C);
  assign sample_o  = busy_q && (cnt_q == SAMPLE_C);
endmodule

// File: rtl/bpr_bit_recovery.sv
module bpr_bit_recovery #(
  parameter int TICKS_PER_BIT = 12,
  parameter int SYNC_STAGES   = 2,
  parameter int DROP_TICK     = 3,
  parameter int SAMPLE_TICK   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic data_o,
  output logic bit_rdy_o,
  output logic strobe_o
);
  import bpr_pkg::*;

  logic line_s;
  logic edge_hit;
  logic in_cell;
  logic drop_hit;
  logic sample_hit;
  logic got_bit;
  logic edge_lvl_q;

  bpr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  bpr_edge_det edge_i (
    .clk(clk), .rst_n(rst_n), .line_s(line_s),
    .armed_i(!in_cell), .load_i(sample_hit),
    .want_lvl_i(bpr_next_level(line_s)), .edge_hit_o(edge_hit)
  );

  bpr_cell_timer #(
    .TICKS_PER_BIT(TICKS_PER_BIT), .DROP_TICK(DROP_TICK), .SAMPLE_TICK(SAMPLE_TICK)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .start_i(edge_hit),
    .in_cell_o(in_cell), .drop_o(drop_hit), .sample_o(sample_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o     <= 1'b0;
      bit_rdy_o  <= 1'b0;
      strobe_o   <= 1'b0;
      got_bit    <= 1'b0;
      edge_lvl_q <= 1'b0;
    end else begin
      bit_rdy_o <= edge_hit && got_bit;
      if (edge_hit) edge_lvl_q <= line_s;
      if (drop_hit) strobe_o <= 1'b0;
      if (sample_hit) begin
        strobe_o <= 1'b1;
        data_o   <= bpr_decode(edge_lvl_q, line_s);
        got_bit  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bpr_bit_recovery_chk.sv
module bpr_bit_recovery_chk (
  input logic clk,
  input logic rst_n,
  input logic data_o,
  input logic bit_rdy_o,
  input logic strobe_o,
  input logic edge_hit,
  input logic in_cell,
  input logic drop_hit,
  input logic sample_hit,
  input logic got_bit
);
  p_no_rdy_before_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !got_bit |-> !bit_rdy_o);

  p_rdy_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rdy_o |=> !bit_rdy_o);

  p_rdy_after_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rdy_o |-> $past(edge_hit));

  p_strobe_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_hit |=> !strobe_o);

  p_strobe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hit |=> strobe_o);

  p_blind_in_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cell && $past(in_cell)) |-> !bit_rdy_o);

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_hit) |-> $stable(data_o));
endmodule

bind bpr_bit_recovery bpr_bit_recovery_chk chk_i (
  .clk(clk), .rst_n(rst_n), .data_o(data_o), .bit_rdy_o(bit_rdy_o),
  .strobe_o(strobe_o), .edge_hit(edge_hit), .in_cell(in_cell),
  .drop_hit(drop_hit), .sample_hit(sample_hit), .got_bit(got_bit)
);

// File: tb/bpr_bit_recovery_tb_top.sv
module bpr_bit_recovery_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b0;
  logic data_o, bit_rdy_o, strobe_o;

  always #2 clk = ~clk;   // 250 MHz

  bpr_bit_recovery dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .data_o(data_o), .bit_rdy_o(bit_rdy_o), .strobe_o(strobe_o)
  );

  localparam int NVEC = 6;
  // Stimulus bytes (sent MSB first); zeros carry a mid-cell change in every cell (R6).
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h96, 8'h3C, 8'h01};

  int   checks = 0;
  int   fails  = 0;
  int   tick   = 0;
  int   bnd_tick = 0;
  int   since  = 99;
  int   pulses = 0;
  int   wr_ptr = 0;
  int   rd_ptr = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;
  logic lvl    = 1'b0;
  logic exp_q [512];

  always @(posedge clk) tick <= tick + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One biphase cell: boundary change always, mid-cell change only for a 0 (R2).
  task automatic send_bit(input logic b);
    @(negedge clk);
    lvl = ~lvl; line_i = lvl; bnd_tick = tick;
    exp_q[wr_ptr] = b; wr_ptr++;
    repeat (6) @(negedge clk);
    if (!b) begin lvl = ~lvl; line_i = lvl; end
    repeat (5) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!mon_en) since = 99;
    else begin
      if (bit_rdy_o) begin
        pulses++;
        check(rd_ptr < wr_ptr, "R1 unexpected pulse", rd_ptr, wr_ptr);
        check(tick - bnd_tick == 3, "R3 latency", tick - bnd_tick, 3);
        check(data_o == exp_q[rd_ptr], "R2,R4 announced bit", data_o, exp_q[rd_ptr]);
        rd_ptr++;
        since = 0;
      end else if (since < 99) since++;
      if (since == 1) check(!bit_rdy_o, "R3 single clock", bit_rdy_o, 0);
      if (since == 3) check(!strobe_o, "R5 strobe low", strobe_o, 0);
      if (since == 6) begin
        check(!strobe_o, "R5 strobe before sample", strobe_o, 0);
        check(data_o == exp_q[rd_ptr-1], "R7 data held", data_o, exp_q[rd_ptr-1]);
      end
      if (since == 7) begin
        check(strobe_o, "R5 strobe at sample", strobe_o, 1);
        check(data_o == exp_q[rd_ptr], "R7,R6 data at sample", data_o, exp_q[rd_ptr]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    check(!data_o && !bit_rdy_o && !strobe_o, "R8 reset state",
          {data_o, bit_rdy_o, strobe_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 7; i >= 0; i--) send_bit(VEC[v][i]);
    end
    send_bit(1'b0);   // flush: its boundary announces the last table bit
    repeat (4) @(negedge clk);
    check(pulses == NVEC * 8, "R3 pulse count", pulses, NVEC * 8);

    // Mid-stream reset and restart
    send_bit(1'b1); send_bit(1'b0);
    mon_en = 1'b0; rst_n = 1'b0; lvl = 1'b0; line_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!data_o && !bit_rdy_o && !strobe_o, "R8 reset mid-stream",
          {data_o, bit_rdy_o, strobe_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_ptr = wr_ptr; p0 = pulses; mon_en = 1'b1;
    send_bit(1'b1);
    check(pulses == p0, "R1 first boundary silent", pulses - p0, 0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b1);
    repeat (4) @(negedge clk);
    check(pulses - p0 == 5, "R1,R4 restart decode count", pulses - p0, 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule